// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device side of a three-wire serial control bus. An external host uses it to read and write a bank of sixteen 16-bit control registers. The bus has three signals: an active-low select, a serial clock and one bidirectional data line. The block is clocked only by the serial clock, so register access works even when no other clock is running. The data line is split into an input, an output value and an output enable, and the pad cell combines them into the one wire.

Each access begins with a nine-bit control word. It holds a four-bit chip identifier, a read/write flag and a four-bit register index, and the flag sits between the third and fourth identifier bits. A write then carries 16 data bits into the selected register. A read leaves the line idle for half a clock and then returns the register contents, one bit per rising edge, so the host can sample each bit on the following falling edge. A transfer that is addressed to another chip, or that the host cuts short, leaves every register untouched. The full register bank is also presented in parallel to the logic the registers control.

Top module: `serial_reg_slave`

## Requirements
- R1: While reset is asserted, and right after it is released, `sdioOe` is low and every register reads as zero.
- R2: A transfer begins at the first rising `sclk` edge that sees `sen` low. The first nine such edges capture the control word in this order: ID3, ID2, ID1, RW, ID0, IX3, IX2, IX1, IX0. The block responds only when ID3..ID0 equals 4'b0110. IX3..IX0 selects the register.
- R3: When RW is 0, edges 10 to 25 capture the data word, most significant bit first. The selected register changes only at edge 25, and then takes the whole word. Register k appears on `regFileFlat[16*k +: 16]`.
- R4: When RW is 1, `sdioOe` stays low through edge 9, which gives the half-cycle turnaround. Edge 10 raises `sdioOe` and presents data bit 15. Each later rising edge presents the next lower bit, and edge 25 presents bit 0.
- R5: The first rising edge that sees `sen` high lowers `sdioOe` and returns the block to idle.
- R6: If the chip identifier does not match, `sdioOe` never rises and no register changes until a rising edge sees `sen` high.
- R7: If `sen` is high at any edge before the 25th bit edge, the transfer is aborted and no register is modified.
- R8: Rising edges that see `sen` high leave the registers and `sdioOe` unchanged, whatever value `sdioIn` has.
- R9: Edges that see `sen` low after the 25th bit edge change nothing. A completed write keeps its value, and a read keeps driving bit 0. A new transfer can start only after an edge that sees `sen` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bus clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sen | input | 1 | Active-low transfer select |
| sdioIn | input | 1 | Value seen on the data line |
| sdioOut | output | 1 | Value the block drives onto the data line |
| sdioOe | output | 1 | High when the block drives the data line |
| regFileFlat | output | NUM_REGS*DATA_W | All registers, register k at bits 16*k+15 down to 16*k |

## Verification
The bench sends control words whose identifier differs from 4'b0110 only in the bit that follows the flag. A design that mixes up the interleaved order would therefore accept these foreign writes, or turn on its driver for foreign reads. It aborts writes after 20 and 24 edges. A design that committed early, or that committed bits as they arrived, would corrupt the register there. It also records the output enable at every edge of a read. This catches a driver that turns on at edge 9 and so skips the turnaround, and a driver that stays on after `sen` rises. Writes that run past 25 edges would reveal trailing bits shifted into the register.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Number of chip-identifier bits carried in the control word
  localparam int CHIP_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD,
    ST_SKIP
  } xferState_t;

  // One-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic shiftCmd;
    logic shiftWr;
    logic commit;
    logic loadRd;
    logic shiftRd;
    logic dropBus;
  } strobe_t;

endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int CMD_W  = 9,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic             sclk,
  input  logic             rstN,
  input  logic             sen,
  input  logic             cmdMatch,
  input  logic             cmdRead,
  output strobe_t          stb,
  output xferState_t       state,
  output logic [CNT_W-1:0] bitCnt
);

  localparam int LAST_CMD = CMD_W - 1;
  localparam int FIRST_RD = CMD_W;
  localparam int LAST_BIT = CMD_W + DATA_W - 1;

  xferState_t       nState;
  logic [CNT_W-1:0] nCnt;

  always_comb begin
    nState = state;
    nCnt   = bitCnt;
    stb    = '0;
    if (sen) begin
      nState      = ST_IDLE;
      nCnt        = '0;
      stb.dropBus = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stb.shiftCmd = 1'b1;
          nCnt         = CNT_W'(1);
          nState       = ST_CMD;
        end
        ST_CMD: begin
          stb.shiftCmd = 1'b1;
          nCnt         = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(LAST_CMD)) begin
            if (!cmdMatch)    nState = ST_SKIP;
            else if (cmdRead) nState = ST_RDATA;
            else              nState = ST_WDATA;
          end
        end
        ST_WDATA: begin
          stb.shiftWr = 1'b1;
          nCnt        = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(LAST_BIT)) begin
            stb.commit = 1'b1;
            nState     = ST_SKIP;
          end
        end
        ST_RDATA: begin
          if (bitCnt == CNT_W'(FIRST_RD)) stb.loadRd  = 1'b1;
          else                            stb.shiftRd = 1'b1;
          nCnt = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(LAST_BIT)) nState = ST_HOLD;
        end
        ST_HOLD, ST_SKIP: begin
          nState = state;
        end
        default: begin
          nState = ST_IDLE;
          nCnt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nState;
      bitCnt <= nCnt;
    end
  end

endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int                NUM_REGS = 16,
  parameter int                DATA_W   = 16,
  parameter int                REG_AW   = 4,
  parameter int                CMD_W    = 9,
  parameter logic [CHIP_W-1:0] CHIP_ID  = 4'b0110
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       sdioIn,
  input  strobe_t                    stb,
  output logic                       cmdMatch,
  output logic                       cmdRead,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic [NUM_REGS*DATA_W-1:0] regFileFlat
);

  // Control word layout, first bit at the top:
  // upper identifier bits, read flag, lowest identifier bit, register index
  localparam int RW_POS = REG_AW + 1;

  logic [CMD_W-2:0]  cmdShift;
  logic [CMD_W-1:0]  nextCmd;
  logic [CHIP_W-1:0] chipSeen;
  logic [REG_AW-1:0] regIdx;
  logic [DATA_W-1:0] wrShift;
  logic [DATA_W-1:0] rdShift;
  logic [DATA_W-1:0] wrWord;
  logic [DATA_W-1:0] regBank [NUM_REGS];

  assign nextCmd  = {cmdShift, sdioIn};
  assign chipSeen = {nextCmd[CMD_W-1 -: CHIP_W-1], nextCmd[REG_AW]};
  assign cmdMatch = (chipSeen == CHIP_ID);
  assign cmdRead  = nextCmd[RW_POS];
  assign regIdx   = cmdShift[REG_AW-1:0];
  assign wrWord   = {wrShift[DATA_W-2:0], sdioIn};

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      cmdShift <= '0;
      wrShift  <= '0;
    end else begin
      if (stb.shiftCmd) cmdShift <= nextCmd[CMD_W-2:0];
      if (stb.shiftWr)  wrShift  <= wrWord;
    end
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_REGS; k++) regBank[k] <= '0;
    end else if (stb.commit) begin
      regBank[regIdx] <= wrWord;
    end
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0;
      sdioOut <= 1'b0;
      sdioOe  <= 1'b0;
    end else begin
      if (stb.dropBus) begin
        sdioOe <= 1'b0;
      end else if (stb.loadRd) begin
        sdioOe  <= 1'b1;
        sdioOut <= regBank[regIdx][DATA_W-1];
        rdShift <= {regBank[regIdx][DATA_W-2:0], 1'b0};
      end else if (stb.shiftRd) begin
        sdioOut <= rdShift[DATA_W-1];
        rdShift <= {rdShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regFileFlat[g*DATA_W +: DATA_W] = regBank[g];
  end

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import srs_pkg::*;
#(
  parameter int                NUM_REGS = 16,
  parameter int                DATA_W   = 16,
  parameter logic [CHIP_W-1:0] CHIP_ID  = 4'b0110
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       sen,
  input  logic                       sdioIn,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic [NUM_REGS*DATA_W-1:0] regFileFlat
);

  localparam int REG_AW = $clog2(NUM_REGS);
  localparam int CMD_W  = CHIP_W + 1 + REG_AW;
  localparam int CNT_W  = $clog2(CMD_W + DATA_W + 1);

  strobe_t          stb;
  xferState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             cmdMatch;
  logic             cmdRead;

  srs_ctrl #(
    .CMD_W (CMD_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) ctrl_i (
    .sclk    (sclk),
    .rstN    (rstN),
    .sen     (sen),
    .cmdMatch(cmdMatch),
    .cmdRead (cmdRead),
    .stb     (stb),
    .state   (state),
    .bitCnt  (bitCnt)
  );

  srs_datapath #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .REG_AW  (REG_AW),
    .CMD_W   (CMD_W),
    .CHIP_ID (CHIP_ID)
  ) dp_i (
    .sclk       (sclk),
    .rstN       (rstN),
    .sdioIn     (sdioIn),
    .stb        (stb),
    .cmdMatch   (cmdMatch),
    .cmdRead    (cmdRead),
    .sdioOut    (sdioOut),
    .sdioOe     (sdioOe),
    .regFileFlat(regFileFlat)
  );

endmodule

// File: rtl/srs_chk.sv
module srs_chk
  import srs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int CMD_W    = 9,
  parameter int CNT_W    = 5
) (
  input logic                       sclk,
  input logic                       rstN,
  input logic                       sen,
  input logic                       sdioOe,
  input logic [NUM_REGS*DATA_W-1:0] regFileFlat,
  input xferState_t                 state,
  input logic [CNT_W-1:0]           bitCnt
);

  localparam int LAST_BIT = CMD_W + DATA_W - 1;

  // R5
  release_on_sen_chk: assert property (@(posedge sclk) disable iff (!rstN)
    sen |=> !sdioOe);

  // R8
  idle_regs_stable_chk: assert property (@(posedge sclk) disable iff (!rstN)
    sen |=> $stable(regFileFlat));

  // R3
  commit_at_last_bit_chk: assert property (@(posedge sclk) disable iff (!rstN)
    !$stable(regFileFlat) |-> ($past(bitCnt) == CNT_W'(LAST_BIT)));

  // R4
  drive_only_in_read_chk: assert property (@(posedge sclk) disable iff (!rstN)
    sdioOe |-> (state == ST_RDATA || state == ST_HOLD));

  // R6
  no_drive_when_skipping_chk: assert property (@(posedge sclk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdioOe);

  // R9
  count_bounded_chk: assert property (@(posedge sclk) disable iff (!rstN)
    bitCnt <= CNT_W'(LAST_BIT + 1));

endmodule

bind serial_reg_slave srs_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .CMD_W   (CMD_W),
  .CNT_W   (CNT_W)
) chk_i (.*);

// File: tb/serial_reg_slave_tb.sv
module serial_reg_slave_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int NREG       = 16;
  localparam int DW         = 16;
  localparam logic [3:0] MY_ID = 4'b0110;

  logic sclk   = 1'b0;
  logic rstN   = 1'b0;
  logic sen    = 1'b1;
  logic sdioIn = 1'b0;
  logic sdioOut;
  logic sdioOe;
  logic [NREG*DW-1:0] regFileFlat;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NREG];

  always #(CLK_PERIOD/2) sclk = ~sclk;

  serial_reg_slave dut_i (
    .sclk       (sclk),
    .rstN       (rstN),
    .sen        (sen),
    .sdioIn     (sdioIn),
    .sdioOut    (sdioOut),
    .sdioOe     (sdioOe),
    .regFileFlat(regFileFlat)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] oeMask(input int first, input int last);
    logic [31:0] m = '0;
    for (int i = first; i <= last; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Runs nEdges select-low edges, then one select-high edge.
  // oeTrace[i] = sdioOe after edge i; oeTrace[0] = after the closing edge.
  task automatic xfer(input bit rw, input logic [3:0] chip, input logic [3:0] idx,
                      input logic [DW-1:0] wdata, input int nEdges,
                      output logic [DW-1:0] rdata, output logic [31:0] oeTrace);
    logic [24:0] bits;
    bits    = {chip[3:1], rw, chip[0], idx, wdata};
    rdata   = '0;
    oeTrace = '0;
    for (int i = 1; i <= nEdges; i++) begin
      @(negedge sclk);
      if (i > 1) begin
        oeTrace[i-1] = sdioOe;
        if (i - 1 >= 10 && i - 1 <= 25) rdata = {rdata[DW-2:0], sdioOut};
      end
      sen    = 1'b0;
      sdioIn = (i <= 25) ? bits[25-i] : 1'b1;
    end
    @(negedge sclk);
    oeTrace[nEdges] = sdioOe;
    if (nEdges >= 10 && nEdges <= 25) rdata = {rdata[DW-2:0], sdioOut};
    sen    = 1'b1;
    sdioIn = ~sdioIn;
    @(negedge sclk);
    oeTrace[0] = sdioOe;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      sdioIn = ~sdioIn;
    end
  endtask

  task automatic test_reset();
    chk("R1", "oe after reset", {31'b0, sdioOe}, 32'd0);
    chk("R1", "any reg nonzero", {31'b0, |regFileFlat}, 32'd0);
  endtask

  task automatic test_write_read();
    logic [DW-1:0] rd;
    logic [31:0] tr;
    xfer(1'b0, MY_ID, 4'd3, 16'hA5C3, 25, rd, tr);
    model[3] = 16'hA5C3;
    chk("R3", "reg3 after write", {16'b0, regFileFlat[3*DW +: DW]}, {16'b0, model[3]});
    chk("R3", "oe during write", tr, 32'd0);
    xfer(1'b1, MY_ID, 4'd3, 16'h0000, 25, rd, tr);
    chk("R4", "read data reg3", {16'b0, rd}, 32'h0000A5C3);
    chk("R4", "oe trace read", tr, oeMask(10, 25));
    chk("R5", "oe after release", {31'b0, tr[0]}, 32'd0);
  endtask

  task automatic test_msb_order();
    logic [DW-1:0] rd;
    logic [31:0] tr;
    xfer(1'b0, MY_ID, 4'd0, 16'h8001, 25, rd, tr);
    model[0] = 16'h8001;
    xfer(1'b0, MY_ID, 4'd15, 16'h7FFE, 25, rd, tr);
    model[15] = 16'h7FFE;
    chk("R3", "reg0 msb first", {16'b0, regFileFlat[0 +: DW]}, 32'h00008001);
    chk("R2", "reg15 index", {16'b0, regFileFlat[15*DW +: DW]}, 32'h00007FFE);
    xfer(1'b1, MY_ID, 4'd15, 16'h0000, 25, rd, tr);
    chk("R4", "read reg15", {16'b0, rd}, 32'h00007FFE);
  endtask

  task automatic test_foreign_chip();
    logic [DW-1:0] rd;
    logic [31:0] tr;
    // only the bit after the flag differs from the own identifier
    xfer(1'b0, 4'b0111, 4'd5, 16'hDEAD, 25, rd, tr);
    chk("R6", "foreign write reg5", {16'b0, regFileFlat[5*DW +: DW]}, {16'b0, model[5]});
    xfer(1'b1, 4'b0111, 4'd3, 16'h0000, 25, rd, tr);
    chk("R6", "foreign read oe", tr, 32'd0);
    xfer(1'b1, 4'b1110, 4'd0, 16'h0000, 28, rd, tr);
    chk("R2", "wrong upper id oe", tr, 32'd0);
  endtask

  task automatic test_abort();
    logic [DW-1:0] rd;
    logic [31:0] tr;
    xfer(1'b0, MY_ID, 4'd3, 16'h1234, 20, rd, tr);
    chk("R7", "abort at 20 keeps reg3", {16'b0, regFileFlat[3*DW +: DW]}, {16'b0, model[3]});
    xfer(1'b0, MY_ID, 4'd3, 16'h1234, 24, rd, tr);
    chk("R7", "abort at 24 keeps reg3", {16'b0, regFileFlat[3*DW +: DW]}, {16'b0, model[3]});
    xfer(1'b1, MY_ID, 4'd3, 16'h0000, 15, rd, tr);
    chk("R7", "aborted read oe trace", tr, oeMask(10, 15));
    xfer(1'b1, MY_ID, 4'd3, 16'h0000, 25, rd, tr);
    chk("R7", "read after aborts", {16'b0, rd}, {16'b0, model[3]});
  endtask

  task automatic test_idle_ignored();
    logic [NREG*DW-1:0] snap;
    snap = regFileFlat;
    idle(30);
    chk("R8", "regs during select high", {31'b0, regFileFlat !== snap}, 32'd0);
    chk("R8", "oe during select high", {31'b0, sdioOe}, 32'd0);
  endtask

  task automatic test_overlong();
    logic [DW-1:0] rd;
    logic [31:0] tr;
    xfer(1'b0, MY_ID, 4'd9, 16'h3C5A, 28, rd, tr);
    model[9] = 16'h3C5A;
    chk("R9", "overlong write reg9", {16'b0, regFileFlat[9*DW +: DW]}, 32'h00003C5A);
    xfer(1'b1, MY_ID, 4'd9, 16'h0000, 28, rd, tr);
    chk("R9", "overlong read data", {16'b0, rd}, 32'h00003C5A);
    chk("R9", "overlong read oe", tr, oeMask(10, 28));
  endtask

  task automatic test_back_to_back();
    logic [DW-1:0] rd;
    logic [31:0] tr;
    xfer(1'b0, MY_ID, 4'd7, 16'hFFFF, 25, rd, tr);
    model[7] = 16'hFFFF;
    xfer(1'b0, MY_ID, 4'd8, 16'h0001, 25, rd, tr);
    model[8] = 16'h0001;
    xfer(1'b1, MY_ID, 4'd7, 16'h0000, 25, rd, tr);
    chk("R3", "back to back reg7", {16'b0, rd}, 32'h0000FFFF);
    xfer(1'b1, MY_ID, 4'd8, 16'h0000, 25, rd, tr);
    chk("R4", "back to back reg8", {16'b0, rd}, 32'h00000001);
  endtask

  task automatic test_final_bank();
    for (int k = 0; k < NREG; k++)
      chk("R3", $sformatf("bank reg%0d", k), {16'b0, regFileFlat[k*DW +: DW]}, {16'b0, model[k]});
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (3) @(negedge sclk);
    test_reset();
    rstN = 1'b1;
    @(negedge sclk);
    test_reset();
    test_write_read();
    test_msb_order();
    test_foreign_chip();
    test_abort();
    test_idle_ignored();
    test_overlong();
    test_back_to_back();
    test_idle_ignored();
    test_final_bank();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule